// File: doc/BRIEF.md
# Packed Single Lane Insert Unit

The unit assembles a four-lane vector of 32-bit elements. It starts from a destination vector, writes one 32-bit element into a chosen lane, and then clears any lanes named by a zero mask. An 8-bit control word fixes all three choices. The element comes from one of two places. In vector mode it is one lane of a 128-bit source vector, chosen by the control word. In scalar mode it is a bare 32-bit word, as when the operand comes from memory.

The inputs are sampled when `in_valid` is high. The result is registered and appears one clock later, with `out_valid` marking it. The unit does no address generation and no memory reads. It does not interpret the lane contents as floating-point values.

Top module: `lane_insert_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `out_valid` = 0 and `out_vec` = 0.
- R2: After reset, `out_valid` equals the value `in_valid` had at the previous rising edge.
- R3: In vector mode (`src_is_scalar` = 0), the inserted element is source lane `ctrl[7:6]`.
- R4: The element lands in lane `ctrl[5:4]`. Every other lane that is not masked carries the matching lane of `dst_vec`.
- R5: If `ctrl[k]` is set (k = 0..3), lane k of the result is zero. This mask acts after the insert, so it can clear the lane that was just written.
- R6: In scalar mode (`src_is_scalar` = 1), the element is `src_scalar` itself. `ctrl[7:6]` and `src_vec` have no effect.
- R7: In vector mode, `src_scalar` has no effect on the result.
- R8: When `in_valid` is low at an edge, `out_vec` keeps its previous value.
- R9: Lane k of every vector occupies bits 32k+31 down to 32k, so lane 0 is bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| ctrl | input | 8 | [7:6] source lane, [5:4] destination lane, [3:0] zero mask |
| src_is_scalar | input | 1 | 1 selects the scalar source, 0 selects the vector source |
| dst_vec | input | 128 | Destination vector |
| src_vec | input | 128 | Source vector (vector mode) |
| src_scalar | input | 32 | Source element (scalar mode) |
| out_valid | output | 1 | Result valid |
| out_vec | output | 128 | Registered result vector |

## Verification
All 256 control words are applied in both source modes, each with fresh random operands. This separates a wrong source-lane pick from a wrong destination lane, and it catches a mask applied before the insert rather than after it. Directed patterns then cover the following:
- Masking the lane that was just inserted.
- Using lane 0 as the destination, which pins down the bit placement.
- Changing only `src_scalar` in vector mode.
- Holding `in_valid` low while every other input changes.

These show that the unused inputs really have no effect and that the register holds.

// File: rtl/lins_pkg.sv
`timescale 1ns/1ps
package lins_pkg;
    localparam int DEF_LANE_W = 32;
    localparam int DEF_LANES  = 4;

    typedef enum logic {
        SRC_VECTOR = 1'b0,
        SRC_SCALAR = 1'b1
    } src_mode_e;

    // width of a lane index field
    function automatic int sel_w(input int lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

    // control word: source index, destination index, one mask bit per lane
    function automatic int ctrl_w(input int lanes);
        return 2 * sel_w(lanes) + lanes;
    endfunction
endpackage

// File: rtl/lins_ctrl_split.sv
`timescale 1ns/1ps
module lins_ctrl_split #(
    parameter  int LANES = lins_pkg::DEF_LANES,
    localparam int SW    = lins_pkg::sel_w(LANES),
    localparam int CW    = lins_pkg::ctrl_w(LANES)
) (
    input  logic [CW-1:0]    ctrl_raw,
    output logic [SW-1:0]    src_sel,
    output logic [SW-1:0]    dst_sel,
    output logic [LANES-1:0] zmask
);
    // field order is fixed: source index on top, mask at the bottom
    typedef struct packed {
        logic [SW-1:0]    src;
        logic [SW-1:0]    dst;
        logic [LANES-1:0] zm;
    } ctrl_t;

    ctrl_t fields;

    assign fields  = ctrl_t'(ctrl_raw);
    assign src_sel = fields.src;
    assign dst_sel = fields.dst;
    assign zmask   = fields.zm;
endmodule

// File: rtl/lins_elem_pick.sv
`timescale 1ns/1ps
module lins_elem_pick #(
    parameter  int LANE_W = lins_pkg::DEF_LANE_W,
    parameter  int LANES  = lins_pkg::DEF_LANES,
    localparam int SW     = lins_pkg::sel_w(LANES),
    localparam int VEC_W  = LANE_W * LANES
) (
    input  logic [VEC_W-1:0]     src_vec,
    input  logic [LANE_W-1:0]    src_scalar,
    input  lins_pkg::src_mode_e  mode,
    input  logic [SW-1:0]        src_sel,
    output logic [LANE_W-1:0]    elem
);
    logic [LANE_W-1:0] lane_arr [LANES];
    logic [LANE_W-1:0] picked;

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lane_arr[g] = src_vec[g*LANE_W +: LANE_W];
    end

    // index out of range (non power-of-two lane count) falls back to lane 0
    always_comb begin
        picked = lane_arr[0];
        for (int i = 1; i < LANES; i++) begin
            if (src_sel == SW'(i)) picked = lane_arr[i];
        end
    end

    // a scalar source skips the lane selection entirely
    assign elem = (mode == lins_pkg::SRC_SCALAR) ? src_scalar : picked;
endmodule

// File: rtl/lins_lane_merge.sv
`timescale 1ns/1ps
module lins_lane_merge #(
    parameter  int LANE_W = lins_pkg::DEF_LANE_W,
    parameter  int LANES  = lins_pkg::DEF_LANES,
    localparam int SW     = lins_pkg::sel_w(LANES),
    localparam int VEC_W  = LANE_W * LANES
) (
    input  logic [VEC_W-1:0]  dst_vec,
    input  logic [LANE_W-1:0] elem,
    input  logic [SW-1:0]     dst_sel,
    input  logic [LANES-1:0]  zmask,
    output logic [VEC_W-1:0]  res_vec
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] ins;
        // insert first, then mask: a masked target lane ends up zero
        assign ins = (dst_sel == SW'(g)) ? elem : dst_vec[g*LANE_W +: LANE_W];
        assign res_vec[g*LANE_W +: LANE_W] = zmask[g] ? '0 : ins;
    end
endmodule

// File: rtl/lane_insert_unit.sv
`timescale 1ns/1ps
module lane_insert_unit #(
    parameter  int LANE_W = lins_pkg::DEF_LANE_W,
    parameter  int LANES  = lins_pkg::DEF_LANES,
    localparam int VEC_W  = LANE_W * LANES,
    localparam int SW     = lins_pkg::sel_w(LANES),
    localparam int CW     = lins_pkg::ctrl_w(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CW-1:0]     ctrl,
    input  logic              src_is_scalar,
    input  logic [VEC_W-1:0]  dst_vec,
    input  logic [VEC_W-1:0]  src_vec,
    input  logic [LANE_W-1:0] src_scalar,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_vec
);
    logic [SW-1:0]       src_sel;
    logic [SW-1:0]       dst_sel;
    logic [LANES-1:0]    zmask;
    logic [LANE_W-1:0]   elem;
    logic [VEC_W-1:0]    res_vec;
    lins_pkg::src_mode_e mode;

    assign mode = lins_pkg::src_mode_e'(src_is_scalar);

    lins_ctrl_split #(.LANES(LANES)) u_split (
        .ctrl_raw (ctrl),
        .src_sel  (src_sel),
        .dst_sel  (dst_sel),
        .zmask    (zmask)
    );

    lins_elem_pick #(.LANE_W(LANE_W), .LANES(LANES)) u_pick (
        .src_vec    (src_vec),
        .src_scalar (src_scalar),
        .mode       (mode),
        .src_sel    (src_sel),
        .elem       (elem)
    );

    lins_lane_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
        .dst_vec (dst_vec),
        .elem    (elem),
        .dst_sel (dst_sel),
        .zmask   (zmask),
        .res_vec (res_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_vec <= res_vec;
        end
    end
endmodule

// File: rtl/lane_insert_chk.sv
`timescale 1ns/1ps
module lane_insert_chk #(
    parameter  int LANE_W = lins_pkg::DEF_LANE_W,
    parameter  int LANES  = lins_pkg::DEF_LANES,
    localparam int VEC_W  = LANE_W * LANES,
    localparam int SW     = lins_pkg::sel_w(LANES),
    localparam int CW     = lins_pkg::ctrl_w(LANES)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [CW-1:0]     ctrl,
    input logic              src_is_scalar,
    input logic [VEC_W-1:0]  dst_vec,
    input logic [VEC_W-1:0]  src_vec,
    input logic [LANE_W-1:0] src_scalar,
    input logic              out_valid,
    input logic [VEC_W-1:0]  out_vec
);
    logic              armed, p_valid, p_scalar;
    logic [CW-1:0]     p_ctrl;
    logic [VEC_W-1:0]  p_dst, p_src;
    logic [LANE_W-1:0] p_sc;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            p_valid  <= 1'b0;
            p_scalar <= 1'b0;
            p_ctrl   <= '0;
            p_dst    <= '0;
            p_src    <= '0;
            p_sc     <= '0;
        end else begin
            armed    <= 1'b1;
            p_valid  <= in_valid;
            p_scalar <= src_is_scalar;
            p_ctrl   <= ctrl;
            p_dst    <= dst_vec;
            p_src    <= src_vec;
            p_sc     <= src_scalar;
        end
    end

    logic [SW-1:0]     p_ssel, p_dsel;
    logic [LANES-1:0]  p_zm;
    logic [LANE_W-1:0] p_src_lane, out_at_dst;

    assign p_ssel     = p_ctrl[CW-1 -: SW];
    assign p_dsel     = p_ctrl[CW-SW-1 -: SW];
    assign p_zm       = p_ctrl[LANES-1:0];
    assign p_src_lane = p_src[p_ssel*LANE_W +: LANE_W];
    assign out_at_dst = out_vec[p_dsel*LANE_W +: LANE_W];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_vec == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (out_valid == p_valid));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !p_valid) |-> $stable(out_vec));

    // R3
    vector_ins_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && p_valid && !p_scalar && !p_zm[p_dsel]) |-> (out_at_dst == p_src_lane));

    // R6
    scalar_ins_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && p_valid && p_scalar && !p_zm[p_dsel]) |-> (out_at_dst == p_sc));

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // R5
        zero_lane_chk: assert property (@(posedge clk) disable iff (rst)
            (armed && p_valid && p_zm[k]) |-> (out_vec[k*LANE_W +: LANE_W] == '0));
        // R4
        keep_lane_chk: assert property (@(posedge clk) disable iff (rst)
            (armed && p_valid && !p_zm[k] && p_dsel != SW'(k))
            |-> (out_vec[k*LANE_W +: LANE_W] == p_dst[k*LANE_W +: LANE_W]));
    end
endmodule

bind lane_insert_unit lane_insert_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .ctrl          (ctrl),
    .src_is_scalar (src_is_scalar),
    .dst_vec       (dst_vec),
    .src_vec       (src_vec),
    .src_scalar    (src_scalar),
    .out_valid     (out_valid),
    .out_vec       (out_vec)
);

// File: tb/lane_insert_unit_bench.sv
`timescale 1ns/1ps
module lane_insert_unit_bench;
    localparam int LW = 32;
    localparam int NL = 4;
    localparam int VW = LW * NL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [7:0]    ctrl = '0;
    logic          src_is_scalar = 1'b0;
    logic [VW-1:0] dst_vec = '0;
    logic [VW-1:0] src_vec = '0;
    logic [LW-1:0] src_scalar = '0;
    logic          out_valid;
    logic [VW-1:0] out_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    lane_insert_unit u_lane_insert_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ctrl(ctrl),
        .src_is_scalar(src_is_scalar), .dst_vec(dst_vec), .src_vec(src_vec),
        .src_scalar(src_scalar), .out_valid(out_valid), .out_vec(out_vec)
    );

    // expected result from the requirement text: pick, insert, then mask
    function automatic logic [VW-1:0] model(input logic [7:0] c, input logic sc_mode,
                                            input logic [VW-1:0] d, input logic [VW-1:0] s,
                                            input logic [LW-1:0] sc);
        logic [VW-1:0] r;
        logic [LW-1:0] e;
        int ssel = int'(c[7:6]);
        int dsel = int'(c[5:4]);
        e = sc_mode ? sc : s[ssel*LW +: LW];
        r = d;
        r[dsel*LW +: LW] = e;
        for (int k = 0; k < NL; k++) if (c[k]) r[k*LW +: LW] = '0;
        return r;
    endfunction

    function automatic logic [VW-1:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // inputs change just after a falling edge; result read at the next falling edge
    task automatic step(input logic v, input logic [7:0] c, input logic m,
                        input logic [VW-1:0] d, input logic [VW-1:0] s, input logic [LW-1:0] sc);
        in_valid = v; ctrl = c; src_is_scalar = m;
        dst_vec = d; src_vec = s; src_scalar = sc;
        @(negedge clk);
    endtask

    initial begin
        #500000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] d, s, last, r1;
        logic [LW-1:0] sc;
        @(negedge clk);
        // R1: reset with valid inputs present
        rst = 1'b1;
        step(1'b1, 8'h30, 1'b1, rnd128(), rnd128(), $urandom);
        step(1'b1, 8'h30, 1'b1, rnd128(), rnd128(), $urandom);
        check("R1 out_valid", VW'(out_valid), '0);
        check("R1 out_vec", out_vec, '0);
        rst = 1'b0;
        step(1'b0, 8'h00, 1'b0, rnd128(), rnd128(), $urandom);
        check("R2 idle valid", VW'(out_valid), '0);
        check("R8 idle hold", out_vec, '0);

        // full control sweep in both modes (R3 vector, R6 scalar, R4/R5 in both)
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 256; c++) begin
                d = rnd128(); s = rnd128(); sc = $urandom;
                step(1'b1, 8'(c), 1'(m), d, s, sc);
                check("R2 valid", VW'(out_valid), VW'(1));
                check(m ? "R6 scalar sweep" : "R3 vector sweep", out_vec,
                      model(8'(c), 1'(m), d, s, sc));
            end
        end

        // R8: inputs change while in_valid is low
        last = out_vec;
        step(1'b0, 8'h0F, 1'b1, rnd128(), rnd128(), $urandom);
        check("R2 drop", VW'(out_valid), '0);
        check("R8 hold 1", out_vec, last);
        step(1'b0, 8'hC0, 1'b0, rnd128(), rnd128(), $urandom);
        check("R8 hold 2", out_vec, last);

        // R5: mask clears the lane just written (dst lane 2, mask bit 2)
        d = rnd128(); s = rnd128();
        step(1'b1, {2'd1, 2'd2, 4'b0100}, 1'b0, d, s, $urandom);
        check("R5 masked insert lane", {96'd0, out_vec[95:64]}, '0);
        check("R5 other lanes", {out_vec[127:96], 32'd0, out_vec[63:0]},
              {d[127:96], 32'd0, d[63:0]});

        // R9: scalar into lane 0 lands in bits 31:0
        d = rnd128(); sc = $urandom;
        step(1'b1, 8'hC0, 1'b1, d, rnd128(), sc);
        check("R9 lane0 bits", {96'd0, out_vec[31:0]}, {96'd0, sc});
        check("R4 upper lanes kept", {out_vec[127:32], 32'd0}, {d[127:32], 32'd0});

        // R4: vector lane 3 into destination lane 1
        d = rnd128(); s = rnd128();
        step(1'b1, {2'd3, 2'd1, 4'b0000}, 1'b0, d, s, $urandom);
        check("R4 lane1 from src lane3", {96'd0, out_vec[63:32]}, {96'd0, s[127:96]});

        // R7: scalar input changes alone in vector mode
        d = rnd128(); s = rnd128();
        step(1'b1, {2'd2, 2'd0, 4'b1000}, 1'b0, d, s, 32'h0000_0000);
        r1 = out_vec;
        step(1'b1, {2'd2, 2'd0, 4'b1000}, 1'b0, d, s, 32'hFFFF_FFFF);
        check("R7 scalar ignored", out_vec, r1);
        check("R7 vs model", out_vec, model({2'd2, 2'd0, 4'b1000}, 1'b0, d, s, 32'h0));

        // R6: src_vec and ctrl[7:6] changes in scalar mode have no effect
        d = rnd128(); sc = $urandom;
        step(1'b1, {2'd0, 2'd3, 4'b0001}, 1'b1, d, rnd128(), sc);
        r1 = out_vec;
        step(1'b1, {2'd2, 2'd3, 4'b0001}, 1'b1, d, rnd128(), sc);
        check("R6 src ignored", out_vec, r1);

        step(1'b0, 8'h00, 1'b0, '0, '0, '0);
        check("R2 final idle", VW'(out_valid), '0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule